// File: doc/BRIEF.md
# Double-Banked Corner-Turn Buffer for a Row/Column 2D Transform

This block sits between the row-wise 1D transform and the column-wise 1D transform of a two-dimensional transform on an N×N frame. Samples arrive one per accepted cycle in row-major order, as a real part and an imaginary part. They leave in column-major order, so the column engine sees each column as a contiguous burst. The buffer holds two banks, and each bank keeps the real half and the imaginary half of a sample side by side. One bank is filled in row order while the other is drained in column order. The two banks swap roles at every frame boundary, so a continuous input stream gives a continuous output stream with no idle gap.

One counter drives the whole block. Its value is the write address, and the same value with its two halves exchanged is the read address. Its wrap toggles the bank select, and a delayed copy of that select steers the output multiplexer. The transpose therefore costs no cycles beyond the memory read. The block never restores row order, so downstream logic receives transposed results. Reading is locked to writing: an input beat both writes one sample and reads one sample. A stall on the input therefore stalls the output by the same amount. Output starts only once a complete frame has been stored.

Top module: `corner_turn_buf`

## Requirements
- R1: After reset, out_valid and out_sof are 0. No sample is output until N² input samples have been accepted since reset.
- R2: Each accepted input beat that reads a filled bank produces exactly one output beat two clock cycles later. The first output beat after reset comes two cycles after the first sample of the second frame.
- R3: Within an output frame, output beat k (0 ≤ k < N²) carries the sample written at row k mod N, column k div N of the corresponding input frame. The input row index is the upper half of the row-major write position and the column index is the lower half.
- R4: The real and imaginary parts of each sample stay paired and unchanged through the buffer.
- R5: With in_valid held high, out_valid stays high every cycle once output has started. Consecutive out_sof pulses are exactly N² cycles apart.
- R6: out_sof is 1 only on beat 0 of each output frame, and only together with out_valid.
- R7: Cycles with in_valid low advance neither the write position nor the read position. out_valid is low exactly two cycles after each such cycle, and the column order resumes correctly afterwards.
- R8: The bank being written changes exactly when the last sample of a frame is accepted. A frame is output intact while the following frame is being written.
- R9: A reset in the middle of a frame discards the partial frame and all stored frames. The block returns to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input sample is present this cycle |
| in_re | input | W | Real part of the input sample (row-major) |
| in_im | input | W | Imaginary part of the input sample |
| out_valid | output | 1 | An output sample is present this cycle |
| out_sof | output | 1 | Marks beat 0 of each transposed frame |
| out_re | output | W | Real part of the output sample (column-major) |
| out_im | output | W | Imaginary part of the output sample |

## Verification
The bench predicts out_valid cycle by cycle from its own count of accepted samples. That exposes a buffer that starts reading before a frame is complete, one that inserts a bubble at the bank swap, and one whose latency drifts under input stalls. Every sample carries a value that encodes its frame, row and column, so an unswapped address, a wrong bank choice at the frame boundary, or a frame overwritten before it was read shows up as a data mismatch. Input gaps placed at irregular positions check that idle cycles advance no counter. A reset in the middle of a frame checks that a primed design does not emit the old bank's contents afterwards.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/ctb_addr_gen.sv
module ctb_addr_gen
  import ctb_pkg::*;
#(
  parameter int LOG_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [2*LOG_N-1:0] wr_addr,
  output logic [2*LOG_N-1:0] rd_addr,
  output bank_e             wr_bank,
  output logic              primed
);
  localparam int AW = 2 * LOG_N;
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      wr_bank <= BANK_A;
      primed  <= 1'b0;
    end else if (adv) begin
      pos <= pos + 1'b1;
      if (pos == LAST) begin
        wr_bank <= other_bank(wr_bank);
        primed  <= 1'b1;
      end
    end
  end

  // row-major write position {row, col}; transposed read {col, row}
  assign wr_addr = pos;
  assign rd_addr = {pos[LOG_N-1:0], pos[AW-1:LOG_N]};
endmodule

// File: rtl/ctb_bank.sv
module ctb_bank #(
  parameter int AW = 8,
  parameter int W  = 15
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wre,
  input  logic [W-1:0]  wim,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rre,
  output logic [W-1:0]  rim
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_re [DEPTH];
  logic [W-1:0] mem_im [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_re[waddr] <= wre;
      mem_im[waddr] <= wim;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rre <= mem_re[raddr];
      rim <= mem_im[raddr];
    end
  end
endmodule

// File: rtl/ctb_out_stage.sv
module ctb_out_stage
  import ctb_pkg::*;
#(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic         sof_now,
  input  bank_e        rd_bank,
  input  logic [W-1:0] bank_re [2],
  input  logic [W-1:0] bank_im [2],
  output logic         out_valid,
  output logic         out_sof,
  output logic [W-1:0] out_re,
  output logic [W-1:0] out_im
);
  logic  v1, s1;
  bank_e sel1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      s1        <= 1'b0;
      sel1      <= BANK_A;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      v1        <= fire;
      s1        <= sof_now;
      sel1      <= rd_bank;
      out_valid <= v1;
      out_sof   <= s1;
      out_re    <= bank_re[sel1];
      out_im    <= bank_im[sel1];
    end
  end
endmodule

// File: rtl/corner_turn_buf.sv
module corner_turn_buf
  import ctb_pkg::*;
#(
  parameter int LOG_N = 4,
  parameter int W     = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_re,
  input  logic [W-1:0] in_im,
  output logic         out_valid,
  output logic         out_sof,
  output logic [W-1:0] out_re,
  output logic [W-1:0] out_im
);
  localparam int AW = 2 * LOG_N;

  logic [AW-1:0] wr_addr, rd_addr;
  bank_e         wr_bank;
  logic          primed;
  logic          fire, sof_now;
  logic [W-1:0]  bank_re [2];
  logic [W-1:0]  bank_im [2];

  ctb_addr_gen #(.LOG_N(LOG_N)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .adv     (in_valid),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .wr_bank (wr_bank),
    .primed  (primed)
  );

  assign fire    = in_valid && primed;
  assign sof_now = fire && (wr_addr == '0);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic mine;
    assign mine = ((wr_bank == BANK_B) == (b == 1));

    ctb_bank #(.AW(AW), .W(W)) u_bank (
      .clk   (clk),
      .we    (in_valid && mine),
      .waddr (wr_addr),
      .wre   (in_re),
      .wim   (in_im),
      .re    (fire && !mine),
      .raddr (rd_addr),
      .rre   (bank_re[b]),
      .rim   (bank_im[b])
    );
  end

  ctb_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .sof_now   (sof_now),
    .rd_bank   (other_bank(wr_bank)),
    .bank_re   (bank_re),
    .bank_im   (bank_im),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_re    (out_re),
    .out_im    (out_im)
  );
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int LOG_N = 4
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_sof,
  input logic wr_bank
);
  localparam int AW = 2 * LOG_N;
  localparam logic [AW:0]   FULL = (AW+1)'(1 << AW);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW:0]   seen;
  logic [AW-1:0] icnt, ocnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      icnt <= '0;
      ocnt <= '0;
    end else begin
      if (in_valid && seen != FULL) seen <= seen + 1'b1;
      if (in_valid)  icnt <= icnt + 1'b1;
      if (out_valid) ocnt <= ocnt + 1'b1;
    end
  end

  assert_unprimed_silent_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen == FULL));

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  assert_sof_position_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sof == (ocnt == '0)));

  assert_sof_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  assert_bank_swap_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && icnt == LAST) |=> (wr_bank != $past(wr_bank)));

  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && icnt == LAST) |=> $stable(wr_bank));
endmodule

bind corner_turn_buf ctb_checker #(.LOG_N(LOG_N)) u_ctb_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .wr_bank   (wr_bank)
);

// File: tb/corner_turn_buf_bench.sv
`timescale 1ns/1ps
module corner_turn_buf_bench;
  localparam int LOG_N = 4;
  localparam int W     = 15;
  localparam int N     = 1 << LOG_N;
  localparam int NN    = N * N;
  localparam int MASK  = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_re = '0, in_im = '0;
  logic out_valid, out_sof;
  logic [W-1:0] out_re, out_im;

  always #10 clk = ~clk;  // 50 MHz

  corner_turn_buf #(.LOG_N(LOG_N), .W(W)) u_corner_turn_buf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_sof(out_sof), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, errors = 0;
  int epoch = 0, out_seen = 0, cyc = 0, last_sof = 0;
  bit cont_mode = 0, have_sof = 0;
  logic ev1 = 0, ev2 = 0;
  int acc = 0;

  function automatic int val_re(int ep, int f, int r, int c);
    return ((ep * 8 + f) * NN + r * N + c) & MASK;
  endfunction
  function automatic int val_im(int ep, int f, int r, int c);
    return (val_re(ep, f, r, c) * 3 + 1) & MASK;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // independent model of when output must be valid
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      ev1 <= 0; ev2 <= 0; acc <= 0;
    end else begin
      ev1 <= in_valid && (acc >= NN);
      ev2 <= ev1;
      if (in_valid && acc < NN) acc <= acc + 1;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst) begin
      out_seen = 0;
    end else begin
      check(out_valid == ev2, "R7 out_valid timing (R1/R2)", out_valid, ev2);
      if (out_valid) begin
        int k, f, r, c;
        k = out_seen % NN;
        f = out_seen / NN;
        r = k % N;
        c = k / N;
        check(out_re == val_re(epoch, f, r, c), "R3 transposed real", out_re, val_re(epoch, f, r, c));
        check(out_im == val_im(epoch, f, r, c), "R4 paired imag", out_im, val_im(epoch, f, r, c));
        check(out_sof == (k == 0), "R6 sof position", out_sof, k == 0);
        if (out_sof && cont_mode) begin
          if (have_sof) check(cyc - last_sof == NN, "R5 sof spacing", cyc - last_sof, NN);
          last_sof = cyc;
          have_sof = 1;
        end
        out_seen++;
      end else begin
        check(out_sof == 0, "R6 sof without valid", out_sof, 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic send_frame(input int f, input bit gaps, input int count, input bit probe);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      if (probe && i == 1) check(out_valid == 0, "R2 not yet valid", out_valid, 0);
      if (probe && i == 2) begin
        check(out_valid == 1, "R2 first output two cycles on", out_valid, 1);
        check(out_sof == 1, "R2 first output is sof", out_sof, 1);
      end
      in_valid = 1;
      in_re = W'(val_re(epoch, f, i / N, i % N));
      in_im = W'(val_im(epoch, f, i / N, i % N));
      if (gaps && (i % 7 == 3 || i % 11 == 5)) begin
        @(negedge clk);
        in_valid = 0;
      end
    end
  endtask

  task automatic t_reset_state();
    rst = 1;
    idle(3);
    check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    check(out_sof == 0, "R1 reset out_sof", out_sof, 0);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_priming_and_stream();
    send_frame(0, 0, NN, 0);
    check(out_seen == 0, "R1 silent during first frame", out_seen, 0);
    cont_mode = 1;
    have_sof = 0;
    send_frame(1, 0, NN, 1);
    send_frame(2, 0, NN, 0);
    send_frame(3, 0, NN, 0);
    idle(3);
    cont_mode = 0;
    check(out_seen == 3 * NN, "R5 continuous frame count (R8)", out_seen, 3 * NN);
  endtask

  task automatic t_stalls();
    send_frame(4, 1, NN, 0);
    send_frame(5, 1, NN, 0);
    send_frame(6, 1, NN, 0);
    idle(3);
    check(out_seen == 6 * NN, "R7 stalled frames complete", out_seen, 6 * NN);
  endtask

  task automatic t_mid_reset();
    send_frame(7, 0, NN / 2, 0);
    @(negedge clk);
    in_valid = 0;
    rst = 1;
    epoch = 1;
    idle(2);
    rst = 0;
    send_frame(0, 0, NN, 0);
    idle(3);
    check(out_seen == 0, "R9 no output after reset priming", out_seen, 0);
    send_frame(1, 0, NN, 0);
    idle(3);
    check(out_seen == NN, "R9 fresh frame output", out_seen, NN);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_priming_and_stream();
    t_stalls();
    t_mid_reset();
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule